// File: doc/BRIEF.md
# Serial Shift-Clock Prescaler

This block derives the serial clock for a three-wire synchronous serial master from the module clock. The division happens in two cascaded stages. The first stage is shared by all chip selects and divides by 2, 4, 7 or 10. The second stage divides the first-stage rate by 2, 4 or 8. Its setting is taken from the configuration field of whichever chip select the master is currently addressing.

The shift engine raises `busy_i` for the length of a transfer. While `busy_i` is high and the block is enabled, `sclk_o` toggles. Each toggle comes with a one-cycle `rise_o` or `fall_o` strobe that tells the engine when to shift or sample. Outside a transfer, `sclk_o` rests at its idle level, which is low, or high when inversion is selected.

Divider and inversion settings are captured only while no transfer is running, so a transfer always keeps a constant bit rate.

Top module: `sclk_prescaler`

## Requirements
- R1: During and straight after reset, `sclk_o`, `rise_o` and `fall_o` are all low.
- R2: `div1_sel_i` encodes the first-stage ratio N1 as follows: 0 gives 2, 1 gives 4, 2 gives 7 and 3 gives 10.
- R3: A 2-bit second-stage code gives the ratio N2 as follows: 0 gives 2, 1 gives 4, 2 gives 8, and the reserved code 3 also gives 8.
- R4: The second-stage code comes from `cs_div_i[2*k+1:2*k]`, where k is the value of `cs_sel_i`.
- R5: In a transfer, each SCLK phase lasts H = N1*N2/2 cycles. The first edge strobe follows H rising clock edges after `busy_i` is sampled high, and every later strobe follows H edges after the one before it.
- R6: While idle, `sclk_o` equals the captured `sclk_inv_i`. The first edge of a transfer leaves that level. `rise_o` is high only in the cycle in which `sclk_o` becomes 1, and `fall_o` only in the cycle in which it becomes 0. The two strobes are never high together.
- R7: One clock edge after `busy_i` is sampled low, both strobes are low and `sclk_o` is back at its idle level. The next transfer restarts both division stages from zero.
- R8: While `clk_en_i` is low, no strobe is produced and `sclk_o` holds its idle level, even with `busy_i` high.
- R9: Changes to `div1_sel_i`, `cs_sel_i`, `cs_div_i` or `sclk_inv_i` made while `busy_i` is high have no effect until `busy_i` has been sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_i | input | 1 | Global clock-generation enable |
| div1_sel_i | input | 2 | First-stage ratio select, shared by all chip selects |
| cs_sel_i | input | CS_W | Chip select being addressed |
| cs_div_i | input | 2*NUM_CS | Second-stage code for each chip select, two bits per chip select |
| sclk_inv_i | input | 1 | Selects a high idle level for SCLK |
| busy_i | input | 1 | High while the shift engine runs a transfer |
| sclk_o | output | 1 | Serial clock level |
| rise_o | output | 1 | One-cycle strobe on each SCLK rising edge |
| fall_o | output | 1 | One-cycle strobe on each SCLK falling edge |

## Verification
A wrong first-stage count or a wrong second-stage count changes H. This shows up at the first strobe, within 40 cycles of `busy_i` rising, because the latency from `busy_i` to that strobe and the spacing between strobes are both measured. A wrong phase register or a wrong inversion register gives a first strobe in the wrong direction, or a wrong idle level one cycle after `busy_i` falls. A capture register that updates while `busy_i` is high changes the very next strobe interval, and the transfer-gating test exposes it there.

// File: rtl/psc_pkg.sv
package psc_pkg;
  localparam int CNT1_W = 4;
  localparam int CNT2_W = 3;

  function automatic logic [CNT1_W-1:0] n1_of(input logic [1:0] sel);
    case (sel)
      2'd0:    return CNT1_W'(2);
      2'd1:    return CNT1_W'(4);
      2'd2:    return CNT1_W'(7);
      default: return CNT1_W'(10);
    endcase
  endfunction

  // half of the second-stage ratio, counted in first-stage ticks
  function automatic logic [CNT2_W-1:0] half2_of(input logic [1:0] code);
    case (code)
      2'd0:    return CNT2_W'(1);
      2'd1:    return CNT2_W'(2);
      default: return CNT2_W'(4);
    endcase
  endfunction
endpackage

// File: rtl/psc_cfg.sv
module psc_cfg #(
  parameter int NUM_CS = 4,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  busy_i,
  input  logic [1:0]            div1_sel_i,
  input  logic [CS_W-1:0]       cs_sel_i,
  input  logic [2*NUM_CS-1:0]   cs_div_i,
  input  logic                  sclk_inv_i,
  output logic [1:0]            div1_q_o,
  output logic [1:0]            div2_q_o,
  output logic                  inv_q_o
);
  logic [1:0] cs_fld [NUM_CS];

  for (genvar k = 0; k < NUM_CS; k++) begin : g_fld
    assign cs_fld[k] = cs_div_i[2*k +: 2];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div1_q_o <= '0;
      div2_q_o <= '0;
      inv_q_o  <= 1'b0;
    end else if (!busy_i) begin
      div1_q_o <= div1_sel_i;
      div2_q_o <= cs_fld[cs_sel_i];
      inv_q_o  <= sclk_inv_i;
    end
  end

  assert_div1_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(div1_q_o));
  assert_div2_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(div2_q_o));
  assert_inv_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(inv_q_o));
endmodule

// File: rtl/psc_stage1.sv
module psc_stage1
  import psc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_i,
  input  logic [CNT1_W-1:0] ratio_i,
  output logic              tick_o
);
  logic [CNT1_W-1:0] cnt_q;
  logic              lvl;

  // high phase is the lower half (floor), so /7 is 3 high, 4 low
  assign lvl    = cnt_q < (ratio_i >> 1);
  assign tick_o = act_i && (cnt_q == ratio_i - CNT1_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!act_i || tick_o) cnt_q <= '0;
    else                   cnt_q <= cnt_q + CNT1_W'(1);
  end

  assert_tick_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
  assert_tick_lvl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> $rose(lvl));
endmodule

// File: rtl/psc_stage2.sv
module psc_stage2
  import psc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_i,
  input  logic              tick_i,
  input  logic [CNT2_W-1:0] half_i,
  input  logic              inv_i,
  output logic              sclk_o,
  output logic              rise_o,
  output logic              fall_o
);
  logic [CNT2_W-1:0] cnt_q;
  logic              ph_q;
  logic              edge_now;

  assign edge_now = act_i && tick_i && (cnt_q == half_i - CNT2_W'(1));
  assign sclk_o   = ph_q ^ inv_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      ph_q   <= 1'b0;
      rise_o <= 1'b0;
      fall_o <= 1'b0;
    end else if (!act_i) begin
      cnt_q  <= '0;
      ph_q   <= 1'b0;
      rise_o <= 1'b0;
      fall_o <= 1'b0;
    end else begin
      rise_o <= edge_now && !(~ph_q ^ ~inv_i);
      fall_o <= edge_now &&  (~ph_q ^ ~inv_i);
      if (edge_now) begin
        cnt_q <= '0;
        ph_q  <= ~ph_q;
      end else if (tick_i) begin
        cnt_q <= cnt_q + CNT2_W'(1);
      end
    end
  end

  assert_no_strobe_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_i |=> !(rise_o || fall_o));
  assert_strobe_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_o && fall_o));
endmodule

// File: rtl/sclk_prescaler.sv
module sclk_prescaler
  import psc_pkg::*;
#(
  parameter int NUM_CS = 4,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clk_en_i,
  input  logic [1:0]          div1_sel_i,
  input  logic [CS_W-1:0]     cs_sel_i,
  input  logic [2*NUM_CS-1:0] cs_div_i,
  input  logic                sclk_inv_i,
  input  logic                busy_i,
  output logic                sclk_o,
  output logic                rise_o,
  output logic                fall_o
);
  logic [1:0]        div1_q, div2_q;
  logic              inv_q;
  logic              act;
  logic              tick1;
  logic [CNT1_W-1:0] ratio1;
  logic [CNT2_W-1:0] half2;

  assign act    = busy_i && clk_en_i;
  assign ratio1 = n1_of(div1_q);
  assign half2  = half2_of(div2_q);

  psc_cfg #(.NUM_CS(NUM_CS)) u_cfg (
    .clk_i, .rst_ni, .busy_i, .div1_sel_i, .cs_sel_i, .cs_div_i, .sclk_inv_i,
    .div1_q_o(div1_q), .div2_q_o(div2_q), .inv_q_o(inv_q)
  );

  psc_stage1 u_st1 (
    .clk_i, .rst_ni, .act_i(act), .ratio_i(ratio1), .tick_o(tick1)
  );

  psc_stage2 u_st2 (
    .clk_i, .rst_ni, .act_i(act), .tick_i(tick1), .half_i(half2), .inv_i(inv_q),
    .sclk_o, .rise_o, .fall_o
  );

  assert_rise_level_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> sclk_o);
  assert_fall_level_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |-> !sclk_o);
  assert_idle_level_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> (sclk_o == inv_q));
  assert_disabled_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_i |=> !(rise_o || fall_o));
endmodule

// File: tb/tb_sclk_prescaler.sv
module tb_sclk_prescaler;
  localparam int NUM_CS = 4;
  localparam int CS_W   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_en = 1'b1;
  logic [1:0] div1_sel = '0;
  logic [CS_W-1:0] cs_sel = '0;
  // cs0=3 (/8 reserved), cs1=1 (/4), cs2=0 (/2), cs3=2 (/8)
  logic [2*NUM_CS-1:0] cs_div = 8'b10_00_01_11;
  logic sclk_inv = 1'b0;
  logic busy = 1'b0;
  logic sclk, rise, fall;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  sclk_prescaler #(.NUM_CS(NUM_CS)) dut (
    .clk_i(clk), .rst_ni(rst_n), .clk_en_i(clk_en), .div1_sel_i(div1_sel),
    .cs_sel_i(cs_sel), .cs_div_i(cs_div), .sclk_inv_i(sclk_inv), .busy_i(busy),
    .sclk_o(sclk), .rise_o(rise), .fall_o(fall)
  );

  // {div1, cs, inv, H}
  localparam logic [10:0] VEC [8] = '{
    {2'd0, 2'd2, 1'b0, 6'd2},   // R2 /2, R3 code0 /2
    {2'd1, 2'd1, 1'b0, 6'd8},   // R2 /4, R3 code1 /4
    {2'd2, 2'd2, 1'b0, 6'd7},   // R2 /7
    {2'd3, 2'd3, 1'b1, 6'd40},  // R2 /10, R3 code2 /8
    {2'd2, 2'd0, 1'b1, 6'd28},  // R3 reserved code3 -> /8
    {2'd0, 2'd1, 1'b1, 6'd4},   // R4 cs1
    {2'd3, 2'd2, 1'b0, 6'd10},  // R4 cs2
    {2'd1, 2'd0, 1'b0, 6'd16}   // R4 cs0
  };

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_edge(output int n, output logic r, output logic f);
    n = 0; r = 1'b0; f = 1'b0;
    while (n < 400) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (rise || fall) begin r = rise; f = fall; break; end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    logic r, f;
    repeat (3) @(negedge clk);
    chk("R1 sclk in reset", int'(sclk), 0);
    chk("R1 strobes in reset", int'(rise | fall), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 sclk after reset", int'(sclk), 0);

    for (int i = 0; i < 8; i++) begin
      logic inv;
      inv      = VEC[i][6];
      div1_sel = VEC[i][10:9];
      cs_sel   = VEC[i][8:7];
      sclk_inv = inv;
      repeat (3) @(negedge clk);
      chk("R6 idle level", int'(sclk), int'(inv));
      busy = 1'b1;
      wait_edge(n, r, f);
      chk("R5 first edge latency (R2 R3 R4)", n, int'(VEC[i][5:0]));
      chk("R6 first edge direction", int'(r), int'(!inv));
      chk("R6 level after first edge", int'(sclk), int'(!inv));
      wait_edge(n, r, f);
      chk("R5 edge spacing", n, int'(VEC[i][5:0]));
      chk("R6 second edge direction", int'(f), int'(!inv));
      busy = 1'b0;
      @(negedge clk);
      chk("R7 idle after busy low", int'(sclk), int'(inv));
      chk("R7 no strobe after busy low", int'(rise | fall), 0);
    end

    // R8 disabled: no strobes with busy high
    div1_sel = 2'd0; cs_sel = 2'd2; sclk_inv = 1'b0;
    clk_en = 1'b0;
    repeat (3) @(negedge clk);
    busy = 1'b1;
    n = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (rise || fall || sclk) n++;
    end
    chk("R8 quiet while disabled", n, 0);
    clk_en = 1'b1;
    wait_edge(n, r, f);
    chk("R8 R7 restart after enable", n, 2);

    // R9 changes during transfer are ignored
    busy = 1'b0;
    repeat (3) @(negedge clk);
    busy = 1'b1;
    wait_edge(n, r, f);
    chk("R9 baseline", n, 2);
    div1_sel = 2'd3; cs_sel = 2'd3; sclk_inv = 1'b1;
    wait_edge(n, r, f);
    chk("R9 ratio held during busy", n, 2);
    chk("R9 inversion held during busy", int'(f), 1);
    busy = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 new inversion when idle", int'(sclk), 1);
    busy = 1'b1;
    wait_edge(n, r, f);
    chk("R9 new ratio after idle", n, 40);
    chk("R9 new direction after idle", int'(f), 1);
    busy = 1'b0;
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule